// File: doc/BRIEF.md
# Vectored Memory-Mapped Interrupt Controller

This block collects up to 32 interrupt request lines and presents a single interrupt to a processor, together with a vector that names the most urgent source. Each line is fixed at build time as either level-sensed or rising-edge-sensed. Captured requests are held in a status register. An enable register masks them to form the pending set. The lowest-numbered pending source wins the vector.

Software reaches the block through a plain word-addressed register port with separate read and write strobes and 32-bit data. It acknowledges requests by writing a mask, and changes enables atomically through dedicated set and clear registers. A two-bit master register gates the processor output and the capture of hardware lines independently. While hardware capture is off, software may write the status register directly to force requests. A read returns its data one clock after the read strobe and reflects the state before any write in the same cycle.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Word address 0 reads status, 2 reads enable and 7 reads the master register. Addresses 3, 4 and 5 read as zero. Addresses 8 and above read as zero and ignore writes.
- R2: Address 1 reads the pending set, which is status AND enable. Writes to addresses 1 and 6 change nothing.
- R3: A write to address 3 clears every status bit whose data bit is 1.
- R4: A write to address 4 ORs the data into enable. A write to address 5 clears the enable bits selected by the data. A write to address 2 loads enable directly.
- R5: The master register (address 7) keeps only data bits 1:0. Bit 0 gates the output, and bit 1 enables hardware capture.
- R6: A write to status (address 0) loads it only while master bit 1 is 0. Otherwise the write is ignored.
- R7: Level-sensed line (EDGE_MASK bit 0): while master bit 1 is 1, a line that is high at a clock edge sets its status bit, and the bit stays set after the line falls. While master bit 1 is 0, the line has no effect.
- R8: Edge-sensed line (EDGE_MASK bit 1): while master bit 1 is 1, only a low-to-high change between consecutive clock samples sets the status bit. A line held high does not set the bit again after an acknowledge.
- R9: Address 6 reads the index of the lowest-numbered pending bit, so bit 0 has the highest priority. It reads 0xFFFFFFFF when nothing is pending.
- R10: irq_o is 1 exactly when master bit 0 is 1 and at least one pending bit is set.
- R11: When hardware capture and an acknowledge hit the same status bit in one cycle, the bit ends up set.
- R12: After reset, status, enable, master and the previous-line samples are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_src_i | input | N_SRC | Interrupt request lines, sampled on clk_i |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after bus_rd_i |
| irq_o | output | 1 | Interrupt to the processor |

## Verification
Hardware capture and a software acknowledge can both act on a status bit in the same clock. A level line is held high while its bit is acknowledged, and the bit must survive. An edge line that is held high and acknowledged must stay clear, because no new rise has occurred. Random phases also fire acknowledges, enable updates and master writes while random lines toggle. A bench model built from the requirements judges every read and every cycle of irq_o.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_REGS = 8;

  // Word offsets; software depends on this order.
  typedef enum logic [2:0] {
    REG_STATUS = 3'd0,
    REG_PEND   = 3'd1,
    REG_ENABLE = 3'd2,
    REG_ACK    = 3'd3,
    REG_SET_EN = 3'd4,
    REG_CLR_EN = 3'd5,
    REG_VECTOR = 3'd6,
    REG_MASTER = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irq_sense.sv
module irq_sense #(
  parameter int unsigned       N_SRC     = 32,
  parameter logic [N_SRC-1:0]  EDGE_MASK = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] src_i,
  input  logic             cap_en_i,
  output logic [N_SRC-1:0] set_o
);
  logic [N_SRC-1:0] prev_q;
  logic [N_SRC-1:0] raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= src_i;
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    if (EDGE_MASK[g]) begin : g_edge
      assign raw[g] = src_i[g] & ~prev_q[g];
    end else begin : g_level
      assign raw[g] = src_i[g];
    end
  end

  assign set_o = cap_en_i ? raw : '0;

  // An edge source cannot request in two consecutive cycles.
  p_edge_once_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_o & EDGE_MASK)) |=> ((set_o & EDGE_MASK & $past(set_o)) == '0));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0] req_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    any_o = |req_i;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned      N_SRC     = 32,
  parameter logic [N_SRC-1:0] EDGE_MASK = '0,
  parameter int unsigned      ADDR_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_src_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              irq_o
);
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0]  status_q, status_d;
  logic [N_SRC-1:0]  enable_q, enable_d;
  logic [1:0]        master_q;
  logic [N_SRC-1:0]  pending;
  logic [N_SRC-1:0]  hw_set;
  logic [N_SRC-1:0]  wdata_n;
  logic [IDX_W-1:0]  vec_idx;
  logic              vec_any;
  logic [DATA_W-1:0] vec_word;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              in_rng;
  reg_sel_e          sel;
  logic              wr_hit;
  logic              cap_en;

  assign in_rng  = ((bus_addr_i >> 3) == '0);
  assign sel     = reg_sel_e'(bus_addr_i[2:0]);
  assign wr_hit  = bus_wr_i & in_rng;
  assign wdata_n = bus_wdata_i[N_SRC-1:0];
  assign cap_en  = master_q[1];

  irq_sense #(.N_SRC(N_SRC), .EDGE_MASK(EDGE_MASK)) u_sense (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .src_i    (irq_src_i),
    .cap_en_i (cap_en),
    .set_o    (hw_set)
  );

  assign pending = status_q & enable_q;

  irq_prio_enc #(.N_SRC(N_SRC)) u_prio (
    .req_i (pending),
    .idx_o (vec_idx),
    .any_o (vec_any)
  );

  assign vec_word = vec_any ? DATA_W'(vec_idx) : '1;

  // Hardware capture is applied last so it dominates a same-cycle acknowledge.
  always_comb begin
    status_d = status_q;
    if (wr_hit && sel == REG_STATUS && !cap_en) status_d = wdata_n;
    if (wr_hit && sel == REG_ACK)               status_d = status_d & ~wdata_n;
    status_d = status_d | hw_set;
  end

  always_comb begin
    enable_d = enable_q;
    if (wr_hit) begin
      unique case (sel)
        REG_ENABLE: enable_d = wdata_n;
        REG_SET_EN: enable_d = enable_q | wdata_n;
        REG_CLR_EN: enable_d = enable_q & ~wdata_n;
        default:    enable_d = enable_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      enable_q <= '0;
      master_q <= '0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
      if (wr_hit && sel == REG_MASTER) master_q <= bus_wdata_i[1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (in_rng) begin
      unique case (sel)
        REG_STATUS: rd_mux = DATA_W'(status_q);
        REG_PEND:   rd_mux = DATA_W'(pending);
        REG_ENABLE: rd_mux = DATA_W'(enable_q);
        REG_VECTOR: rd_mux = vec_word;
        REG_MASTER: rd_mux = DATA_W'(master_q);
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= rd_mux;
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = master_q[0] & vec_any;

  p_ack_clears_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && sel == REG_ACK) |=> ((status_q & $past(wdata_n) & ~$past(hw_set)) == '0));

  p_set_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && sel == REG_SET_EN) |=> ((enable_q & $past(wdata_n)) == $past(wdata_n)));

  p_clr_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && sel == REG_CLR_EN) |=> ((enable_q & $past(wdata_n)) == '0));

  p_status_locked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && sel == REG_STATUS && cap_en) |=> (status_q == ($past(status_q) | $past(hw_set))));

  p_hw_set_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_set) |=> ((status_q & $past(hw_set)) == $past(hw_set)));

  p_vec_lowest_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_any |-> (pending[vec_idx] &&
                 ((pending & ((N_SRC'(1) << vec_idx) - N_SRC'(1))) == '0)));

  p_vec_none_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pending == '0) |-> (vec_word == '1));

  p_irq_gate_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (master_q[0] && (status_q & enable_q) != '0));
endmodule

// File: tb/tb_irq_vec_ctrl.sv
`timescale 1ns/1ps
module tb_irq_vec_ctrl;
  localparam logic [31:0] TB_EDGE = 32'hFFFF_0000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] irq_src_i = '0;
  logic [3:0]  bus_addr_i = '0;
  logic        bus_wr_i = 1'b0;
  logic        bus_rd_i = 1'b0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic        irq_o;

  irq_vec_ctrl #(.N_SRC(32), .EDGE_MASK(TB_EDGE), .ADDR_W(4)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_src_i(irq_src_i),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_rd_i(bus_rd_i),
    .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
  );

  always #4 clk_i = ~clk_i;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [31:0] m_st = '0, m_en = '0, m_pv = '0;
  logic [1:0]  m_ms = '0;
  logic [31:0] cur_src = '0;
  logic [31:0] last_rd;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_vec(input logic [31:0] p);
    for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
    return 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return m_st;
      4'd1: return m_st & m_en;
      4'd2: return m_en;
      4'd6: return m_vec(m_st & m_en);
      4'd7: return {30'b0, m_ms};
      default: return 32'h0;
    endcase
  endfunction

  task automatic cyc(input logic [31:0] src, input bit wr, input bit rd,
                     input logic [3:0] a, input logic [31:0] d, input string tag);
    logic [31:0] exp_rd, hw, ns, ne;
    logic [1:0]  nm;
    @(negedge clk_i);
    irq_src_i = src; cur_src = src;
    bus_wr_i = wr; bus_rd_i = rd; bus_addr_i = a; bus_wdata_i = d;
    exp_rd = m_read(a);
    hw = m_ms[1] ? ((src & ~TB_EDGE) | (src & ~m_pv & TB_EDGE)) : 32'h0;
    ns = m_st; ne = m_en; nm = m_ms;
    if (wr && a < 8) begin
      case (a)
        4'd0: if (!m_ms[1]) ns = d;
        4'd2: ne = d;
        4'd3: ns = ns & ~d;
        4'd4: ne = ne | d;
        4'd5: ne = ne & ~d;
        4'd7: nm = d[1:0];
        default: ;
      endcase
    end
    ns = ns | hw;
    @(posedge clk_i);
    m_st = ns; m_en = ne; m_ms = nm; m_pv = src;
    #2;
    bus_wr_i = 1'b0; bus_rd_i = 1'b0;
    check(irq_o == (m_ms[0] && (m_st & m_en) != 0), {tag, " R10 irq_o"},
          32'(irq_o), 32'(m_ms[0] && (m_st & m_en) != 0));
    if (rd) begin
      last_rd = bus_rdata_o;
      check(bus_rdata_o == exp_rd, {tag, " R1 R2 R9 read"}, bus_rdata_o, exp_rd);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    cyc(cur_src, 1'b1, 1'b0, a, d, "wr");
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
    cyc(cur_src, 1'b0, 1'b1, a, 32'h0, tag);
    check(last_rd == exp, tag, last_rd, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    #20 rst_ni = 1'b1;
    #1;
    check(irq_o == 1'b0, "R12 irq_o after reset", 32'(irq_o), 32'h0);
    rd_check(4'd0, 32'h0, "R12 status");
    rd_check(4'd2, 32'h0, "R12 enable");
    rd_check(4'd7, 32'h0, "R12 master");
    rd_check(4'd6, 32'hFFFF_FFFF, "R9 R12 empty vector");

    wr_reg(4'd7, 32'hFFFF_FFFF);
    rd_check(4'd7, 32'h3, "R5 master width");
    wr_reg(4'd4, 32'h0001_0101);
    rd_check(4'd2, 32'h0001_0101, "R4 set enable");

    // R7: level pulse is held
    cyc(32'h1, 0, 0, 0, 0, "R7");
    cur_src = 32'h0;
    rd_check(4'd0, 32'h1, "R7 level sticky");
    check(irq_o == 1'b1, "R10 irq asserted", 32'(irq_o), 32'h1);
    rd_check(4'd6, 32'h0, "R9 vector 0");
    wr_reg(4'd3, 32'h1);
    rd_check(4'd0, 32'h0, "R3 ack");

    // R8: edge held high, acked, no re-capture
    cyc(32'h1_0000, 0, 0, 0, 0, "R8");
    cyc(32'h1_0000, 1, 0, 4'd3, 32'h1_0000, "R8 ack");
    rd_check(4'd0, 32'h0, "R8 no recapture while held");

    // R11: level held high while acked in the same cycle
    cyc(32'h100, 0, 0, 0, 0, "R11");
    cyc(32'h100, 1, 0, 4'd3, 32'h100, "R11 ack");
    rd_check(4'd0, 32'h100, "R11 capture wins");
    rd_check(4'd6, 32'h8, "R9 vector 8");
    rd_check(4'd1, 32'h100, "R2 pending");

    cur_src = 32'h0;
    wr_reg(4'd5, 32'h100);
    rd_check(4'd1, 32'h0, "R4 clear enable");
    check(irq_o == 1'b0, "R10 no pending", 32'(irq_o), 32'h0);
    wr_reg(4'd7, 32'h2);
    wr_reg(4'd4, 32'h100);
    check(irq_o == 1'b0, "R10 gated by master bit 0", 32'(irq_o), 32'h0);

    wr_reg(4'd0, 32'hF0);
    rd_check(4'd0, 32'h100, "R6 status write blocked");
    wr_reg(4'd1, 32'hFFFF);
    wr_reg(4'd6, 32'hFFFF);
    rd_check(4'd1, 32'h100, "R2 pending not writable");
    wr_reg(4'd7, 32'h1);
    wr_reg(4'd0, 32'hA5);
    rd_check(4'd0, 32'hA5, "R6 status write allowed");
    cyc(32'h2, 0, 0, 0, 0, "R7 off");
    rd_check(4'd0, 32'hA5, "R7 capture off");
    cur_src = 32'h0;

    rd_check(4'd3, 32'h0, "R1 ack reads zero");
    rd_check(4'd4, 32'h0, "R1 set reads zero");
    rd_check(4'd5, 32'h0, "R1 clear reads zero");
    rd_check(4'd9, 32'h0, "R1 out of range read");
    wr_reg(4'd12, 32'hFFFF_FFFF);
    wr_reg(4'd10, 32'h0);
    rd_check(4'd2, 32'h0001_0101, "R1 out of range write");

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] s, d;
      logic [3:0]  a;
      int          op;
      s = cur_src;
      if (($urandom % 4) == 0) s = s ^ ($urandom & $urandom & $urandom);
      op = $urandom % 10;
      a = ($urandom % 12 == 0) ? 4'(8 + $urandom % 8) : 4'($urandom % 8);
      d = (($urandom % 3) == 0) ? $urandom : ($urandom & $urandom & $urandom);
      if (a == 4'd7 && ($urandom % 2) == 0) d = 32'h3;
      if (op < 4)      cyc(s, 1'b1, 1'b0, a, d, "RND R3 R4 R6 R7 R8 R11");
      else if (op < 8) cyc(s, 1'b0, 1'b1, a, 32'h0, "RND R1 R2 R9");
      else             cyc(s, 1'b1, 1'b1, a, d, "RND R5 R10");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule